// File: doc/BRIEF.md
# Transmit Command Stream Parser

The block sits behind a host-written transmit data port. Every 32-bit word the host writes is read as part of a command stream: each buffer segment opens with a command word A, followed by a second command word B, then its data words. Command A carries the segment's byte count, a leading byte offset, first/last segment flags, an end-alignment code and a completion-interrupt request. Command B carries a 16-bit packet tag, and the tag is taken only on the first segment of a frame. A frame may span several segments, and each segment has its own offset and padding.

The parser drops the leading offset bytes and the trailing alignment words. It hands out up to four payload bytes per accepted word on byte lanes with a per-lane valid strobe. When the segment that carries the last-segment flag completes, it pulses end-of-frame with the frame's byte length and pushes a status word into a 512-entry status FIFO. That FIFO can be peeked and popped, and reports its fill level and a full flag. Words written while the data store is at capacity are dropped and flagged. A clear input abandons the frame in progress.

Top module: `tx_cmd_parser`

## Requirements
- R1: After reset the parser expects command A, free_words_o equals the capacity (4608), the status FIFO is empty and not full, and byte_valid_o, frame_end_o, irq_o and ovf_o are low.
- R2: Accepted words cycle through the states command A, then command B, then data. Command A fields are: byte count in bits 10:0, start offset in bits 20:16, last-segment in bit 12, first-segment in bit 13, alignment code in bits 25:24, completion interrupt in bit 31.
- R3: A data word yields its bytes least-significant first, packed from lane 0 upward. At most the remaining byte count is taken. byte_valid_o is a contiguous low mask (0, 1, 3, 7 or 15) and appears the cycle after the write.
- R4: While the remaining offset is 4 or more, a data word is discarded whole and the offset drops by 4. An offset of 1 to 3 drops that many low bytes of the next word.
- R5: The data word count is (count + offset + 3) / 4. Alignment code 1 pads it to a multiple of 4 words, code 2 pads it to a multiple of 8 words, and codes 0 and 3 add no padding. The padding is computed for every segment. After the byte count is exhausted, each further word consumes one padding word.
- R6: A segment completes when both its remaining byte count and its padding are zero. irq_o pulses if bit 31 was set. frame_end_o pulses only if the last-segment bit was set, and frame_len_o then gives the bytes taken since the first segment.
- R7: A completed frame pushes {tag, 16'h0000}, where the tag is bits 31:16 of the command B of its first segment. The command B word of a non-first segment is consumed and has no effect.
- R8: The status FIFO holds 512 entries and shows its oldest entry on stat_data_o. stat_pop_i removes that entry when the FIFO is not empty. stat_full_o is high at 512 entries, and a frame finishing while the FIFO is full adds no entry.
- R9: free_words_o equals the capacity minus a used count. The used count rises for each command A, each latched command B and each data word from which bytes are taken, but not for offset-discarded or padding words. It returns to zero when a frame completes.
- R10: A write while the used count equals the capacity is dropped, leaves all state unchanged and pulses ovf_o.
- R11: clear_i returns the parser to expecting command A and zeroes the used count. A write in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Host word write strobe |
| wr_data_i | input | 32 | Host word |
| clear_i | input | 1 | Abandon frame in progress, clear used count |
| stat_pop_i | input | 1 | Pop one status entry |
| byte_data_o | output | 32 | Payload bytes, lane 0 in bits 7:0 |
| byte_valid_o | output | 4 | Per-lane valid strobe |
| frame_end_o | output | 1 | Pulse when a frame completes |
| frame_len_o | output | 16 | Frame byte length, valid with frame_end_o |
| irq_o | output | 1 | Completion interrupt pulse |
| ovf_o | output | 1 | Dropped-write pulse |
| free_words_o | output | 13 | Free space in words |
| stat_data_o | output | 32 | Oldest status entry (peek) |
| stat_count_o | output | 10 | Status entries held |
| stat_full_o | output | 1 | Status FIFO full |

## Verification
The bench targets an offset of six, which must discard one whole word and then two bytes. A design that only trims bytes would emit offset bytes as payload. It also sends segments whose alignment padding outlasts the data. A wrong word count would end the frame early, which shows up as a misplaced end-of-frame pulse. A two-segment frame checks that the second command B neither replaces the tag nor counts as a used word, and that the length adds up across segments. The bench then fills the data store to exactly 4608 words and the status FIFO to exactly 512 entries. This catches an off-by-one limit, which would either drop a legal write or accept a 513th status entry.

// File: rtl/tx_parse_pkg.sv
package tx_parse_pkg;
  typedef enum logic [1:0] {ST_CMD_A, ST_CMD_B, ST_DATA} parse_state_e;

  localparam int SIZE_W    = 11;
  localparam int OFF_W     = 5;
  localparam int PAD_W     = 3;
  localparam int TAG_W     = 16;
  localparam int OFF_LO    = 16;
  localparam int ALIGN_LO  = 24;
  localparam int LAST_BIT  = 12;
  localparam int FIRST_BIT = 13;
  localparam int IRQ_BIT   = 31;
  localparam logic [31:0] CMD_A_KEEP = 32'h831F_37FF;

  // padding words needed after a segment's data words
  function automatic logic [PAD_W-1:0] pad_words(input logic [1:0] code,
                                                 input logic [SIZE_W-1:0] size,
                                                 input logic [OFF_W-1:0] off);
    logic [12:0] wc;
    logic [12:0] neg;
    wc  = ({2'b0, size} + {8'b0, off} + 13'd3) >> 2;
    neg = 13'd0 - wc;
    case (code)
      2'd1:    return PAD_W'(neg & 13'd3);
      2'd2:    return PAD_W'(neg & 13'd7);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/tx_lane_pick.sv
module tx_lane_pick
  import tx_parse_pkg::*;
(
  input  logic [31:0]       word_i,
  input  logic [1:0]        skip_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [31:0]       data_o,
  output logic [3:0]        mask_o,
  output logic [2:0]        take_o
);
  logic [2:0] room;

  always_comb begin
    room   = 3'd4 - {1'b0, skip_i};
    take_o = (size_i < {8'b0, room}) ? size_i[2:0] : room;
    data_o = word_i >> {skip_i, 3'b000};
    mask_o = 4'((5'd1 << take_o) - 5'd1);
  end
endmodule

// File: rtl/tx_stat_fifo.sv
module tx_stat_fifo #(
  parameter int DEPTH = 512,
  parameter int TAG_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             pop_i,
  output logic [TAG_W-1:0] tag_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  logic [TAG_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic do_push, do_pop;

  assign full_o  = (count_o == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && (count_o != '0);
  assign tag_o   = mem[head_q];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[tail_q] <= tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) tail_q <= bump(tail_q);
      if (do_pop)  head_q <= bump(head_q);
      case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tx_cmd_parser.sv
module tx_cmd_parser
  import tx_parse_pkg::*;
#(
  parameter int CAP_WORDS  = 4608,
  parameter int STAT_DEPTH = 512,
  parameter int LEN_W      = 16,
  localparam int USED_W = $clog2(CAP_WORDS + 1),
  localparam int CNT_W  = $clog2(STAT_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [31:0]       wr_data_i,
  input  logic              clear_i,
  input  logic              stat_pop_i,
  output logic [31:0]       byte_data_o,
  output logic [3:0]        byte_valid_o,
  output logic              frame_end_o,
  output logic [LEN_W-1:0]  frame_len_o,
  output logic              irq_o,
  output logic              ovf_o,
  output logic [USED_W-1:0] free_words_o,
  output logic [31:0]       stat_data_o,
  output logic [CNT_W-1:0]  stat_count_o,
  output logic              stat_full_o
);
  parse_state_e      state_q;
  logic [31:0]       cmd_a_q;
  logic [TAG_W-1:0]  tag_q;
  logic [SIZE_W-1:0] size_q;
  logic [OFF_W-1:0]  off_q;
  logic [PAD_W-1:0]  pad_q;
  logic [USED_W-1:0] used_q;
  logic [LEN_W-1:0]  len_q;

  logic [31:0] pick_data;
  logic [3:0]  pick_mask;
  logic [2:0]  pick_take;
  logic        at_cap, skip_word, pad_word, take_word, seg_done, frame_done;
  logic [SIZE_W-1:0] size_left;
  logic [LEN_W-1:0]  len_next;
  logic [TAG_W-1:0]  stat_tag;

  tx_lane_pick u_pick (
    .word_i (wr_data_i),
    .skip_i (off_q[1:0]),
    .size_i (size_q),
    .data_o (pick_data),
    .mask_o (pick_mask),
    .take_o (pick_take)
  );

  always_comb begin
    at_cap     = (used_q == USED_W'(CAP_WORDS));
    skip_word  = (off_q >= OFF_W'(4));
    pad_word   = (size_q == '0) && (pad_q != '0);
    take_word  = (state_q == ST_DATA) && !skip_word && !pad_word;
    size_left  = size_q - SIZE_W'(pick_take);
    len_next   = len_q + (take_word ? LEN_W'(pick_take) : '0);
    seg_done   = wr_valid_i && !clear_i && !at_cap && (state_q == ST_DATA) && !skip_word &&
                 (pad_word ? (pad_q == PAD_W'(1)) : (size_left == '0 && pad_q == '0));
    frame_done = seg_done && cmd_a_q[LAST_BIT];
  end

  assign free_words_o = USED_W'(CAP_WORDS) - used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_CMD_A;
      cmd_a_q      <= '1;
      tag_q        <= '0;
      size_q       <= '0;
      off_q        <= '0;
      pad_q        <= '0;
      used_q       <= '0;
      len_q        <= '0;
      byte_data_o  <= '0;
      byte_valid_o <= '0;
      frame_end_o  <= 1'b0;
      frame_len_o  <= '0;
      irq_o        <= 1'b0;
      ovf_o        <= 1'b0;
    end else begin
      byte_valid_o <= '0;
      frame_end_o  <= 1'b0;
      irq_o        <= 1'b0;
      ovf_o        <= 1'b0;
      if (clear_i) begin
        state_q <= ST_CMD_A;
        used_q  <= '0;
        cmd_a_q <= '1;
      end else if (wr_valid_i) begin
        if (at_cap) begin
          ovf_o <= 1'b1;
        end else begin
          unique case (state_q)
            ST_CMD_A: begin
              cmd_a_q <= wr_data_i & CMD_A_KEEP;
              size_q  <= wr_data_i[SIZE_W-1:0];
              off_q   <= wr_data_i[OFF_LO +: OFF_W];
              used_q  <= used_q + 1'b1;
              state_q <= ST_CMD_B;
            end
            ST_CMD_B: begin
              if (cmd_a_q[FIRST_BIT]) begin
                tag_q  <= wr_data_i[31:16];
                len_q  <= '0;
                used_q <= used_q + 1'b1;
              end
              pad_q   <= pad_words(cmd_a_q[ALIGN_LO +: 2], size_q, off_q);
              state_q <= ST_DATA;
            end
            default: begin
              if (skip_word) begin
                off_q <= off_q - OFF_W'(4);
              end else if (pad_word) begin
                pad_q <= pad_q - 1'b1;
              end else begin
                byte_data_o  <= pick_data;
                byte_valid_o <= pick_mask;
                size_q       <= size_left;
                off_q        <= '0;
                used_q       <= used_q + 1'b1;
                len_q        <= len_next;
              end
              if (seg_done) begin
                state_q <= ST_CMD_A;
                irq_o   <= cmd_a_q[IRQ_BIT];
                if (cmd_a_q[LAST_BIT]) begin
                  frame_end_o <= 1'b1;
                  frame_len_o <= len_next;
                  used_q      <= '0;
                end
              end
            end
          endcase
        end
      end
    end
  end

  tx_stat_fifo #(.DEPTH(STAT_DEPTH), .TAG_W(TAG_W)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (frame_done),
    .tag_i   (tag_q),
    .pop_i   (stat_pop_i),
    .tag_o   (stat_tag),
    .count_o (stat_count_o),
    .full_o  (stat_full_o)
  );

  assign stat_data_o = {stat_tag, 16'h0000};
endmodule

// File: rtl/tx_cmd_parser_chk.sv
module tx_cmd_parser_chk #(
  parameter int CAP_WORDS = 4608,
  parameter int USED_W    = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              clear_i,
  input logic              stat_pop_i,
  input logic [3:0]        byte_valid_o,
  input logic              frame_end_o,
  input logic              ovf_o,
  input logic [USED_W-1:0] free_words_o,
  input logic              stat_full_o
);
  assert_lane_contig_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o inside {4'h0, 4'h1, 4'h3, 4'h7, 4'hF});

  assert_end_needs_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_end_o) |-> $past(wr_valid_i) && !$past(clear_i));

  assert_free_after_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> free_words_o == USED_W'(CAP_WORDS));

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> free_words_o == '0);

  assert_clear_frees_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> free_words_o == USED_W'(CAP_WORDS));

  assert_full_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_full_o && !stat_pop_i |=> stat_full_o);
endmodule

bind tx_cmd_parser tx_cmd_parser_chk #(.CAP_WORDS(CAP_WORDS), .USED_W(USED_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .clear_i      (clear_i),
  .stat_pop_i   (stat_pop_i),
  .byte_valid_o (byte_valid_o),
  .frame_end_o  (frame_end_o),
  .ovf_o        (ovf_o),
  .free_words_o (free_words_o),
  .stat_full_o  (stat_full_o)
);

// File: tb/tx_cmd_parser_test.sv
module tx_cmd_parser_test;
  localparam int CAP = 4608;
  localparam int SD  = 512;

  typedef struct packed {
    logic [31:0] w;
    logic [3:0]  m;
    logic [31:0] d;
    logic        e;
    logic        q;
    logic [15:0] l;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{32'h8001_3006, 4'h0, 32'h0,         1'b0, 1'b0, 16'd0},
    '{32'hABCD_0000, 4'h0, 32'h0,         1'b0, 1'b0, 16'd0},
    '{32'h4433_2211, 4'h7, 32'h0044_3322, 1'b0, 1'b0, 16'd0},
    '{32'h8877_6655, 4'h7, 32'h0077_6655, 1'b1, 1'b1, 16'd6},
    '{32'h0106_3005, 4'h0, 32'h0,         1'b0, 1'b0, 16'd0},
    '{32'h1234_5678, 4'h0, 32'h0,         1'b0, 1'b0, 16'd0},
    '{32'hDEAD_BEEF, 4'h0, 32'h0,         1'b0, 1'b0, 16'd0},
    '{32'hDDCC_BBAA, 4'h3, 32'h0000_DDCC, 1'b0, 1'b0, 16'd0},
    '{32'h0403_0201, 4'h7, 32'h0003_0201, 1'b0, 1'b0, 16'd0},
    '{32'hCAFE_F00D, 4'h0, 32'h0,         1'b1, 1'b0, 16'd5},
    '{32'h8000_2003, 4'h0, 32'h0,         1'b0, 1'b0, 16'd0},
    '{32'h5555_0000, 4'h0, 32'h0,         1'b0, 1'b0, 16'd0},
    '{32'h00CC_BBAA, 4'h7, 32'h00CC_BBAA, 1'b0, 1'b1, 16'd0},
    '{32'h0203_1002, 4'h0, 32'h0,         1'b0, 1'b0, 16'd0},
    '{32'hFFFF_FFFF, 4'h0, 32'h0,         1'b0, 1'b0, 16'd0},
    '{32'h1122_3344, 4'h1, 32'h0000_0011, 1'b0, 1'b0, 16'd0},
    '{32'h9988_7766, 4'h1, 32'h0000_0066, 1'b0, 1'b0, 16'd0},
    '{32'h0000_0001, 4'h0, 32'h0,         1'b0, 1'b0, 16'd0},
    '{32'h0000_0002, 4'h0, 32'h0,         1'b0, 1'b0, 16'd0},
    '{32'h0000_0003, 4'h0, 32'h0,         1'b0, 1'b0, 16'd0},
    '{32'h0000_0004, 4'h0, 32'h0,         1'b0, 1'b0, 16'd0},
    '{32'h0000_0005, 4'h0, 32'h0,         1'b0, 1'b0, 16'd0},
    '{32'h0000_0006, 4'h0, 32'h0,         1'b1, 1'b0, 16'd5}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic clear = 1'b0;
  logic pop = 1'b0;
  logic [31:0] byte_data;
  logic [3:0]  byte_valid;
  logic frame_end, irq, ovf, stat_full;
  logic [15:0] frame_len;
  logic [12:0] free_words;
  logic [31:0] stat_data;
  logic [9:0]  stat_count;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tx_cmd_parser uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .clear_i(clear), .stat_pop_i(pop), .byte_data_o(byte_data), .byte_valid_o(byte_valid),
    .frame_end_o(frame_end), .frame_len_o(frame_len), .irq_o(irq), .ovf_o(ovf),
    .free_words_o(free_words), .stat_data_o(stat_data), .stat_count_o(stat_count),
    .stat_full_o(stat_full)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    @(negedge clk); wr_valid = 1'b1; wr_data = w;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int model;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 free", 32'(free_words), 32'(CAP));
    check("R1 stat_count", 32'(stat_count), 32'd0);
    check("R1 full/valid/end/irq/ovf", {27'd0, stat_full, byte_valid[0] | byte_valid[3], frame_end, irq, ovf}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 byte_valid", 32'(byte_valid), 32'd0);

    // R2 R3 R4 R5 R6 table walk
    for (int i = 0; i < NV; i++) begin
      put(VEC[i].w);
      check($sformatf("R3 mask vec %0d", i), 32'(byte_valid), 32'(VEC[i].m));
      if (VEC[i].m != 0)
        check($sformatf("R4 data vec %0d", i), byte_data & lanes(VEC[i].m), VEC[i].d);
      check($sformatf("R5 R6 end vec %0d", i), 32'(frame_end), 32'(VEC[i].e));
      check($sformatf("R6 irq vec %0d", i), 32'(irq), 32'(VEC[i].q));
      if (VEC[i].e) check($sformatf("R6 len vec %0d", i), 32'(frame_len), 32'(VEC[i].l));
    end
    check("R2 idle free", 32'(free_words), 32'(CAP));

    // R7 R8 tags in order, peek then pop
    check("R8 count", 32'(stat_count), 32'd3);
    check("R7 peek 0", stat_data, 32'hABCD_0000);
    do_pop();
    check("R7 peek 1", stat_data, 32'h1234_0000);
    do_pop();
    check("R7 second-seg B ignored", stat_data, 32'h5555_0000);
    do_pop();
    check("R8 empty", 32'(stat_count), 32'd0);
    do_pop();
    check("R8 pop empty", 32'(stat_count), 32'd0);

    // R9 used-word accounting across segments
    put(32'h0000_2004);
    check("R9 after A", 32'(free_words), 32'(CAP - 1));
    put(32'h7E7E_0000);
    check("R9 after B", 32'(free_words), 32'(CAP - 2));
    put(32'hAABB_CCDD);
    check("R9 after data", 32'(free_words), 32'(CAP - 3));
    put(32'h0000_1004);
    check("R9 second A", 32'(free_words), 32'(CAP - 4));
    put(32'h1111_1111);
    check("R9 R7 second B not counted", 32'(free_words), 32'(CAP - 4));
    put(32'h0102_0304);
    check("R9 frame end frees", 32'(free_words), 32'(CAP));
    check("R6 len two segments", 32'(frame_len), 32'd8);
    check("R7 first-seg tag", stat_data, 32'h7E7E_0000);
    do_pop();

    // R11 clear mid-frame
    put(32'h0000_3008);
    put(32'h2222_0000);
    do_clear();
    check("R11 free after clear", 32'(free_words), 32'(CAP));
    put(32'h0000_3001);
    put(32'h7777_0000);
    put(32'h0000_005A);
    check("R11 fresh cmd A mask", 32'(byte_valid), 32'h1);
    check("R11 fresh cmd A data", byte_data & 32'hFF, 32'h5A);
    check("R11 fresh frame end", 32'(frame_end), 32'd1);
    check("R11 tag", stat_data, 32'h7777_0000);
    do_pop();

    // R10 fill data store to capacity
    model = 0;
    put(32'h0000_27FC); put(32'h0);
    model = 2;
    for (int k = 0; k < 511; k++) put(32'(k));
    model += 511;
    for (int s = 0; s < 7; s++) begin
      put(32'h0000_07FC); put(32'h0);
      for (int k = 0; k < 511; k++) put(32'(k));
      model += 512;
    end
    put(32'h0000_07F8); put(32'h0);
    for (int k = 0; k < 510; k++) put(32'(k));
    model += 511;
    check("R9 full store", 32'(free_words), 32'(CAP - model));
    put(32'h0000_3004);
    check("R10 ovf pulse", 32'(ovf), 32'd1);
    check("R10 word dropped", 32'(free_words), 32'd0);
    do_clear();
    check("R10 ovf clears", 32'(ovf), 32'd0);

    // R8 status FIFO full
    for (int f = 0; f < SD; f++) begin
      put(32'h0000_3004); put({16'(f), 16'h0}); put(32'h0);
    end
    check("R8 count full", 32'(stat_count), 32'(SD));
    check("R8 full flag", 32'(stat_full), 32'd1);
    put(32'h0000_3004); put(32'hFFFF_0000); put(32'h0);
    check("R8 end when full", 32'(frame_end), 32'd1);
    check("R8 no push when full", 32'(stat_count), 32'(SD));
    check("R8 peek oldest", stat_data, 32'h0000_0000);
    do_pop();
    check("R8 count after pop", 32'(stat_count), 32'(SD - 1));
    check("R8 not full", 32'(stat_full), 32'd0);
    check("R8 next entry", stat_data, 32'h0001_0000);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule